// File: doc/BRIEF.md
# Parity-Protected Write-Through Cache

A direct-mapped cache for a processor load/store port, placed in front of a slower external memory. Each line holds four 32-bit words. Loads that hit are answered from the cache. Loads that miss fetch the whole line from memory. Every store goes straight through to memory. A store that hits also updates the cached copy.

Soft errors in the storage arrays are caught with parity. The tag of each line has one parity bit, and each data word has one. Parity is written along with the value and checked when a lookup hits. When a check fails, the line is dropped and the access is served as a miss, so a clean copy comes back from memory. This recovery works only because the cache never holds the sole copy of any data, which is why there is no write-back mode.

Software scrubs the cache by invalidating lines one index at a time. A fault-injection input flips one stored bit without changing its parity, so the detection and recovery path can be exercised.

Top module: `pcache`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` is 1, and `cpu_ack`, `mem_rd_req` and `mem_wr_req` are 0. The first load to any address causes a refill.
- R2: A load miss raises `mem_rd_req` for exactly one cycle. `mem_rd_addr` is the line base, with byte address bits [3:0] equal to zero. The cache takes exactly four `mem_rd_valid` beats, lowest word first, and answers with the word at the requested offset (address bits [3:2]) in the cycle after the last beat.
- R3: A load that hits with good parity gets `cpu_ack` with its data in the cycle after acceptance, and no memory read is issued.
- R4: Every store shows up on `mem_wr_req` with the CPU's byte address and data. Both stay stable until `mem_wr_ack`, and `cpu_ack` follows in the next cycle.
- R5: A store that hits updates the cached word and its parity. A later load of that word returns the new value without a refill.
- R6: A store that misses does not allocate a line, does not issue a memory read, and does not disturb the line already held at that index.
- R7: Address fields are tag = [31:8] and index = [7:4]. If a stored tag bit is flipped so that the stored tag equals a new address's tag, a load of that new address is treated as a miss. The line is refilled and the load returns memory data, not stale data.
- R8: A flipped bit in the word a load accesses forces a refill. A flipped bit in a different word of the same line does not affect a load of an intact word, which still hits.
- R9: Holding `inv_req` with `inv_index` while idle invalidates that index, and `inv_ack` is 1 in the next cycle. The next load to that index misses. Lines at other indices are unaffected.
- R10: While `inv_req` is 1, `cpu_ready` is 0. A load presented in the same cycle as an invalidate of its line waits, and then misses.
- R11: After parity recovery, the refilled line carries fresh parity and the next load to it hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access valid |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Access accepted when high together with cpu_req |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid with cpu_ack |
| mem_rd_req | output | 1 | One-cycle line refill request |
| mem_rd_addr | output | 32 | Line base byte address |
| mem_rd_valid | input | 1 | Refill beat valid |
| mem_rd_data | input | 32 | Refill beat data |
| mem_wr_req | output | 1 | Write-through request, held until acknowledged |
| mem_wr_addr | output | 32 | Write-through byte address |
| mem_wr_data | output | 32 | Write-through data |
| mem_wr_ack | input | 1 | Write-through accepted |
| inv_req | input | 1 | Line invalidate request |
| inv_index | input | 4 | Line index to invalidate |
| inv_ack | output | 1 | Invalidate done pulse |
| inj_en | input | 1 | Flip one stored bit this cycle |
| inj_tag | input | 1 | 1 = flip a tag bit, 0 = flip a data bit |
| inj_index | input | 4 | Line to corrupt |
| inj_word | input | 2 | Word within the line, for data flips |
| inj_bit | input | 5 | Bit position to flip |

## Verification
A line invalidate and a CPU load can arrive in the same cycle. The bench provokes this by raising `inv_req` and `cpu_req` together, on the very index that the load would hit. It then judges three things:
- `cpu_ready` is held low while the invalidate is pending.
- `inv_ack` appears first.
- The load, once accepted, triggers exactly one refill and returns memory data, which proves the invalidate took effect before the lookup.

The other way the cache's functions meet is a parity failure inside a hit. Here the bench checks that the lookup and the recovery refill combine into a single miss.

// File: rtl/pcache.sv
module pcache #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int LINES      = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cpu_req,
  input  logic                          cpu_we,
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic [WORD_W-1:0]             cpu_wdata,
  output logic                          cpu_ready,
  output logic                          cpu_ack,
  output logic [WORD_W-1:0]             cpu_rdata,
  output logic                          mem_rd_req,
  output logic [ADDR_W-1:0]             mem_rd_addr,
  input  logic                          mem_rd_valid,
  input  logic [WORD_W-1:0]             mem_rd_data,
  output logic                          mem_wr_req,
  output logic [ADDR_W-1:0]             mem_wr_addr,
  output logic [WORD_W-1:0]             mem_wr_data,
  input  logic                          mem_wr_ack,
  input  logic                          inv_req,
  input  logic [$clog2(LINES)-1:0]      inv_index,
  output logic                          inv_ack,
  input  logic                          inj_en,
  input  logic                          inj_tag,
  input  logic [$clog2(LINES)-1:0]      inj_index,
  input  logic [$clog2(LINE_WORDS)-1:0] inj_word,
  input  logic [$clog2(WORD_W)-1:0]     inj_bit
);
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int OFS_W  = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - BYTE_W - OFS_W - IDX_W;
  localparam int WI_W   = IDX_W + OFS_W;
  localparam logic [OFS_W-1:0] LAST = OFS_W'(LINE_WORDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_FREQ, S_FILL, S_WR} st_t;

  st_t                  state;
  logic [TAG_W-1:0]     tag_q  [LINES];
  logic [LINES-1:0]     tpar_q;
  logic [LINES-1:0]     valid_q;
  logic [WORD_W-1:0]    data_q [LINES*LINE_WORDS];
  logic [LINES*LINE_WORDS-1:0] dpar_q;

  logic [ADDR_W-1:0]    s_addr;
  logic [WORD_W-1:0]    s_wdata;
  logic [OFS_W-1:0]     cnt;

  logic [TAG_W-1:0]     a_tag, s_tag;
  logic [IDX_W-1:0]     a_idx, s_idx;
  logic [OFS_W-1:0]     a_ofs, s_ofs;
  logic [WI_W-1:0]      a_wi;
  logic                 tag_match, tag_ok, word_ok, rd_hit, perr, take;

  assign a_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign a_idx = cpu_addr[BYTE_W+OFS_W +: IDX_W];
  assign a_ofs = cpu_addr[BYTE_W +: OFS_W];
  assign a_wi  = {a_idx, a_ofs};
  assign s_tag = s_addr[ADDR_W-1 -: TAG_W];
  assign s_idx = s_addr[BYTE_W+OFS_W +: IDX_W];
  assign s_ofs = s_addr[BYTE_W +: OFS_W];

  assign tag_match = valid_q[a_idx] && (tag_q[a_idx] == a_tag);
  assign tag_ok    = (^tag_q[a_idx]) == tpar_q[a_idx];
  assign word_ok   = (^data_q[a_wi]) == dpar_q[a_wi];
  assign rd_hit    = tag_match && tag_ok && word_ok;
  assign perr      = tag_match && !(tag_ok && (cpu_we || word_ok));

  assign cpu_ready   = (state == S_IDLE) && !inv_req;
  assign take        = cpu_req && cpu_ready;
  assign mem_rd_req  = (state == S_FREQ);
  assign mem_rd_addr = {s_tag, s_idx, {(OFS_W+BYTE_W){1'b0}}};
  assign mem_wr_req  = (state == S_WR);
  assign mem_wr_addr = s_addr;
  assign mem_wr_data = s_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      valid_q   <= '0;
      cpu_ack   <= 1'b0;
      inv_ack   <= 1'b0;
      cpu_rdata <= '0;
      cnt       <= '0;
      s_addr    <= '0;
      s_wdata   <= '0;
    end else begin
      cpu_ack <= 1'b0;
      inv_ack <= 1'b0;
      case (state)
        S_IDLE: begin
          if (inv_req) begin
            valid_q[inv_index] <= 1'b0;
            inv_ack            <= 1'b1;
          end else if (cpu_req) begin
            s_addr  <= cpu_addr;
            s_wdata <= cpu_wdata;
            if (cpu_we) begin
              if (perr) valid_q[a_idx] <= 1'b0;
              state <= S_WR;
            end else if (rd_hit) begin
              cpu_ack   <= 1'b1;
              cpu_rdata <= data_q[a_wi];
            end else begin
              valid_q[a_idx] <= 1'b0;
              state          <= S_FREQ;
            end
          end
        end
        S_FREQ: begin
          cnt   <= '0;
          state <= S_FILL;
        end
        S_FILL: begin
          if (mem_rd_valid) begin
            cnt <= cnt + 1'b1;
            if (cnt == s_ofs) cpu_rdata <= mem_rd_data;
            if (cnt == LAST) begin
              valid_q[s_idx] <= 1'b1;
              cpu_ack        <= 1'b1;
              state          <= S_IDLE;
            end
          end
        end
        S_WR: begin
          if (mem_wr_ack) begin
            cpu_ack <= 1'b1;
            state   <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (inj_en) begin
      if (inj_tag)
        tag_q[inj_index] <= tag_q[inj_index] ^ (TAG_W'(1) << inj_bit);
      else
        data_q[{inj_index, inj_word}] <= data_q[{inj_index, inj_word}] ^ (WORD_W'(1) << inj_bit);
    end
    if (state == S_FILL && mem_rd_valid) begin
      data_q[{s_idx, cnt}] <= mem_rd_data;
      dpar_q[{s_idx, cnt}] <= ^mem_rd_data;
      if (cnt == LAST) begin
        tag_q[s_idx]  <= s_tag;
        tpar_q[s_idx] <= ^s_tag;
      end
    end
    if (take && cpu_we && tag_match && tag_ok) begin
      data_q[a_wi] <= cpu_wdata;
      dpar_q[a_wi] <= ^cpu_wdata;
    end
  end
endmodule

module pcache_chk #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              cpu_ready,
  input logic              cpu_ack,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_wr_req,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [WORD_W-1:0] mem_wr_data,
  input logic              mem_wr_ack,
  input logic              inv_req,
  input logic              inv_ack
);
  localparam int LOW = $clog2(WORD_W / 8) + $clog2(LINE_WORDS);

  p_ready_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req |-> !cpu_ready);

  p_store_through_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_ready && cpu_we) |=> mem_wr_req);

  p_wr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  p_wr_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && mem_wr_ack) |=> cpu_ack);

  p_fill_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (mem_rd_addr[LOW-1:0] == '0));

  p_fill_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req);

  p_inv_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_ack |-> $past(inv_req));
endmodule

bind pcache pcache_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ready(cpu_ready),
  .cpu_ack(cpu_ack), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
  .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
  .mem_wr_ack(mem_wr_ack), .inv_req(inv_req), .inv_ack(inv_ack));

// File: tb/tb_pcache.sv
module tb_pcache;
  logic        clk = 0, rst_n = 0;
  logic        cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic        cpu_ready, cpu_ack;
  logic [31:0] cpu_rdata;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 0;
  logic [31:0] mem_rd_data = 0;
  logic        mem_wr_req;
  logic [31:0] mem_wr_addr, mem_wr_data;
  logic        mem_wr_ack = 0;
  logic        inv_req = 0;
  logic [3:0]  inv_index = 0;
  logic        inv_ack;
  logic        inj_en = 0, inj_tag = 0;
  logic [3:0]  inj_index = 0;
  logic [1:0]  inj_word = 0;
  logic [4:0]  inj_bit = 0;

  int total = 0, bad = 0, rd_cnt = 0, ack_cnt = 0;
  logic [31:0] last_base = 0;
  logic [31:0] wmem [logic [31:0]];
  logic [32:0] rsp_q [$];
  string       rsp_tag [$];
  logic [63:0] wr_q [$];

  always #10 clk = ~clk;

  pcache dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mword(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    if (wmem.exists(w)) return wmem[w];
    return (w * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  always @(negedge clk) begin
    if (rst_n && cpu_ack) begin
      if (rsp_q.size() == 0) chk(0, "R4 unexpected ack", 1, 0);
      else begin
        logic [32:0] it;
        string t;
        it = rsp_q.pop_front();
        t  = rsp_tag.pop_front();
        if (it[32]) chk(cpu_rdata == it[31:0], t, cpu_rdata, it[31:0]);
      end
      ack_cnt++;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd_req) begin
        logic [31:0] b;
        rd_cnt++;
        b = mem_rd_addr;
        last_base = b;
        chk(b[3:0] == 0, "R2 refill base aligned", b, {b[31:4], 4'h0});
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
          mem_rd_valid = 1;
          mem_rd_data  = mword(b + 32'(4 * i));
          @(negedge clk);
        end
        mem_rd_valid = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (mem_wr_ack) mem_wr_ack = 0;
    else if (mem_wr_req) begin
      logic [63:0] e;
      e = (wr_q.size() != 0) ? wr_q.pop_front() : 64'hFFFFFFFF_FFFFFFFF;
      chk(mem_wr_addr == e[63:32], "R4 write-through address", mem_wr_addr, e[63:32]);
      chk(mem_wr_data == e[31:0], "R4 write-through data", mem_wr_data, e[31:0]);
      mem_wr_ack = 1;
    end
  end

  task automatic cpu_read(input logic [31:0] a, input bit miss, input string req);
    int pr, pa;
    pr = rd_cnt; pa = ack_cnt;
    rsp_q.push_back({1'b1, mword(a)});
    rsp_tag.push_back({req, " load data"});
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = a;
    @(negedge clk);
    cpu_req = 0;
    if (!miss) chk(cpu_ack == 1, {req, " hit ack next cycle"}, 32'(cpu_ack), 1);
    wait (ack_cnt != pa);
    chk((rd_cnt - pr) == int'(miss), {req, " refill count"}, 32'(rd_cnt - pr), 32'(miss));
  endtask

  task automatic cpu_write(input logic [31:0] a, input logic [31:0] d, input string req);
    int pr, pa;
    pr = rd_cnt; pa = ack_cnt;
    wmem[{a[31:2], 2'b00}] = d;
    wr_q.push_back({a, d});
    rsp_q.push_back({1'b0, 32'h0});
    rsp_tag.push_back(req);
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
    wait (ack_cnt != pa);
    chk(rd_cnt == pr, {req, " store issues no refill"}, 32'(rd_cnt - pr), 0);
  endtask

  task automatic do_inv(input logic [3:0] idx);
    @(negedge clk);
    inv_req = 1; inv_index = idx;
    @(negedge clk);
    chk(inv_ack == 1, "R9 inv_ack next cycle", 32'(inv_ack), 1);
    inv_req = 0;
  endtask

  task automatic inject(input bit t, input logic [3:0] idx, input logic [1:0] w, input logic [4:0] b);
    @(negedge clk);
    inj_en = 1; inj_tag = t; inj_index = idx; inj_word = w; inj_bit = b;
    @(negedge clk);
    inj_en = 0;
  endtask

  bit done = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cpu_ready == 1, "R1 ready after reset", 32'(cpu_ready), 1);
    chk({cpu_ack, mem_rd_req, mem_wr_req} == 0, "R1 idle outputs", 32'({cpu_ack, mem_rd_req, mem_wr_req}), 0);

    cpu_read(32'h0000_0108, 1, "R1 R2 first load miss");
    chk(last_base == 32'h100, "R2 refill line base", last_base, 32'h100);
    cpu_read(32'h0000_010C, 0, "R3 hit last word");
    cpu_read(32'h0000_0100, 0, "R3 hit first word");
    cpu_read(32'h0000_0204, 1, "R2 conflict miss");
    cpu_read(32'h0000_0100, 1, "R2 refetch evicted");

    cpu_write(32'h0000_0104, 32'hDEAD_BEEF, "R4 R5 store hit");
    cpu_read(32'h0000_0104, 0, "R5 updated word hit");
    cpu_write(32'h0000_3008, 32'h1357_9BDF, "R4 R6 store miss");
    cpu_read(32'h0000_0104, 0, "R6 line kept after store miss");
    cpu_read(32'h0000_3008, 1, "R6 no allocate on store miss");

    cpu_read(32'h0000_0410, 1, "R8 fill index 1");
    inject(0, 4'd1, 2'd2, 5'd5);
    cpu_read(32'h0000_0414, 0, "R8 other word unaffected");
    cpu_read(32'h0000_0418, 1, "R8 data parity refill");
    cpu_read(32'h0000_0418, 0, "R11 hit after data recovery");

    inject(1, 4'd1, 2'd0, 5'd0);
    cpu_read(32'h0000_0510, 1, "R7 tag parity refill");
    cpu_read(32'h0000_051C, 0, "R11 hit after tag recovery");

    cpu_read(32'h0000_0620, 1, "R9 fill index 2");
    do_inv(4'd3);
    cpu_read(32'h0000_0624, 0, "R9 other index unaffected");
    do_inv(4'd2);
    cpu_read(32'h0000_0620, 1, "R9 invalidated line misses");

    begin
      int pr, pa;
      pr = rd_cnt; pa = ack_cnt;
      rsp_q.push_back({1'b1, mword(32'h0000_062C)});
      rsp_tag.push_back("R10 load after invalidate data");
      @(negedge clk);
      inv_req = 1; inv_index = 4'd2;
      cpu_req = 1; cpu_we = 0; cpu_addr = 32'h0000_062C;
      #1;
      chk(cpu_ready == 0, "R10 ready low during invalidate", 32'(cpu_ready), 0);
      @(negedge clk);
      chk(inv_ack == 1, "R10 invalidate served first", 32'(inv_ack), 1);
      inv_req = 0;
      @(negedge clk);
      cpu_req = 0;
      wait (ack_cnt != pa);
      chk((rd_cnt - pr) == 1, "R10 load misses after same-cycle invalidate", 32'(rd_cnt - pr), 1);
    end

    repeat (4) @(negedge clk);
    chk(rsp_q.size() == 0, "R4 all responses seen", 32'(rsp_q.size()), 0);
    chk(wr_q.size() == 0, "R4 all writes seen", 32'(wr_q.size()), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule